// File: doc/BRIEF.md
# 3x3 Neighbourhood Pattern Sieve

This block filters a raster image stream by looking at the 3x3 neighbourhood around every pixel. Pixels arrive one per accepted cycle. The block packs each neighbourhood into a key and looks that key up, in a single cycle, in a small table of trained patterns. A pixel whose neighbourhood is in the table is passed on unchanged. A pixel with any other neighbourhood is replaced by 0. The result is a sparse image that keeps only the structures the table was trained on.

The frame size is fixed by parameters (`COLS` by `ROWS`). Two line buffers hold the rows above the newest pixel, and everything outside the frame counts as 0. Because each output needs the row below it, the last row of a frame is completed by an internal flush. During the flush the block runs for `COLS+1` cycles on its own and ignores its input.

A mode input selects binary pixels, where bit 0 is the pixel and there are 9 key bits, or 4-level grey pixels, where each pixel has 2 bits and the key has 18 bits. The table is loaded through a simple write port, normally between frames.

Top module: `nbhd_sieve`

## Requirements
- R1: While `rst_n` is low and after reset, `out_vld` and `out_pix` are 0 and every table entry is invalid, so with an untouched table every output pixel is 0.
- R2: Pixel k of the neighbourhood is numbered row-major from the top-left (k = 3*row + col, with the centre at k=4). In binary mode (`mode_grey`=0) key bit k is bit 0 of pixel k, and pixel bit 1 has no effect.
- R3: In grey mode (`mode_grey`=1) key bits [2k+1:2k] hold pixel k, which gives an 18-bit key compared against the full stored key.
- R4: A pixel whose key equals the key of a valid entry is output unchanged in grey mode, and as {0, bit 0} in binary mode. Any other pixel is output as 0. When `out_vld` is low, `out_pix` is 0.
- R5: Neighbours outside the frame (row -1, row `ROWS`, column -1, column `COLS`) take the value 0 in the key.
- R6: Each frame yields exactly `ROWS*COLS` outputs, in raster order. With gap-free input, the output for pixel (0,0) appears `COLS+2` clock edges after the edge that accepts pixel (0,0). Each output is driven two edges after the input step that completes its neighbourhood.
- R7: After the last pixel of a frame is accepted, the block flushes for `COLS+1` cycles. During the flush `in_vld`, `in_sof` and `in_pix` are ignored.
- R8: `out_sof` is high only with the output for pixel (0,0), and `out_eol` only with outputs in column `COLS-1`. Neither is ever high without `out_vld`.
- R9: A write with `tw_en` high stores `tw_key` and the valid bit `tw_keep` at entry `tw_idx`. Writing `tw_keep`=0 removes that pattern. A write is used by every lookup from the following cycle on.
- R10: A pixel arriving with `in_vld` high but no `in_sof`, while no frame is open, is ignored and produces no output.
- R11: In binary mode only the lowest 9 bits of a stored key are compared, so bits 17..9 of an entry have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_grey | input | 1 | 1: grey keys (2 bits per pixel), 0: binary keys (bit 0 per pixel) |
| in_vld | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input pixel is pixel (0,0) of a frame |
| in_pix | input | PIX_W (2) | Input pixel value |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | clog2(ENTRIES) (5) | Table entry index |
| tw_key | input | 9*PIX_W (18) | Pattern key to store |
| tw_keep | input | 1 | Valid bit written with the key |
| out_vld | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output pixel is pixel (0,0) |
| out_eol | output | 1 | Output pixel is in the last column |
| out_pix | output | PIX_W (2) | Kept pixel value, or 0 when blanked |

## Verification
The checks assume that `mode_grey` and the table stay constant while a frame is in flight. They also assume that every frame starts with `in_sof` and delivers exactly `ROWS*COLS` pixels. Under these assumptions the marker positions and the binary-mode output width follow from the output stream alone. The stimulus changes the mode and writes the table only after each frame and its flush have finished. Frames are sent both gap-free and with random idle cycles. Junk pixels, including a stray start marker, are deliberately driven during the flush and while no frame is open, because the design must ignore them.

// File: rtl/nbhd_sieve_pkg.sv
package nbhd_sieve_pkg;

   // pixels in one neighbourhood window
   localparam int unsigned WIN_PIX  = 9;
   // window edge length
   localparam int unsigned WIN_EDGE = 3;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_RUN   = 2'd1,
      SEQ_FLUSH = 2'd2
   } seq_state_e;

   function automatic int unsigned key_bits(input int unsigned pix_w);
      return WIN_PIX * pix_w;
   endfunction

endpackage

// File: rtl/nbhd_linebuf.sv
module nbhd_linebuf #(
   parameter int unsigned COLS  = 16,
   parameter int unsigned ROWS  = 8,
   parameter int unsigned PIX_W = 2,
   localparam int unsigned CW   = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int unsigned RW   = $clog2(ROWS + 2),
   localparam int unsigned DEPTH_ROWS = nbhd_sieve_pkg::WIN_EDGE - 1
) (
   input  logic             clk,
   input  logic             step,
   input  logic [CW-1:0]    col,
   input  logic [RW-1:0]    row,
   input  logic [PIX_W-1:0] pix_new,
   output logic [PIX_W-1:0] col_top,
   output logic [PIX_W-1:0] col_mid,
   output logic [PIX_W-1:0] col_bot
);

   // tap[0]: row above the newest pixel, tap[1]: two rows above
   logic [PIX_W-1:0] tap [DEPTH_ROWS];

   for (genvar g = 0; g < DEPTH_ROWS; g++) begin : g_row
      logic [PIX_W-1:0] mem [COLS];
      logic [PIX_W-1:0] wr_d;
      if (g == 0) begin : g_head
         assign wr_d = pix_new;
      end else begin : g_chain
         assign wr_d = tap[g-1];
      end
      always_ff @(posedge clk) begin
         if (step) mem[col] <= wr_d;
      end
      assign tap[g] = mem[col];
   end

   // rows outside the frame read as zero
   always_comb begin
      col_top = (row >= RW'(2))    ? tap[1]  : '0;
      col_mid = (row >= RW'(1))    ? tap[0]  : '0;
      col_bot = (row <  RW'(ROWS)) ? pix_new : '0;
   end

endmodule

// File: rtl/nbhd_keyform.sv
module nbhd_keyform #(
   parameter int unsigned PIX_W = 2,
   localparam int unsigned EDGE = nbhd_sieve_pkg::WIN_EDGE,
   localparam int unsigned CV_W = EDGE * PIX_W,
   localparam int unsigned KEY_W = nbhd_sieve_pkg::key_bits(PIX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [PIX_W-1:0] new_top,
   input  logic [PIX_W-1:0] new_mid,
   input  logic [PIX_W-1:0] new_bot,
   input  logic             kill_left,
   input  logic             kill_right,
   input  logic             emit,
   input  logic             sof_mark,
   input  logic             eol_mark,
   output logic [KEY_W-1:0] key_q,
   output logic [PIX_W-1:0] ctr_q,
   output logic             emit_q,
   output logic             sof_q,
   output logic             eol_q
);

   // packed columns, row i at [i*PIX_W +: PIX_W], row 0 on top
   logic [CV_W-1:0] col_l, col_m;
   logic [CV_W-1:0] col_n;
   logic [CV_W-1:0] wsel [EDGE];
   logic [KEY_W-1:0] key_d;

   assign col_n = {new_bot, new_mid, new_top};

   always_comb begin
      wsel[0] = kill_left  ? '0 : col_l;
      wsel[1] = col_m;
      wsel[2] = kill_right ? '0 : col_n;
   end

   for (genvar i = 0; i < EDGE; i++) begin : g_krow
      for (genvar j = 0; j < EDGE; j++) begin : g_kcol
         assign key_d[(EDGE*i + j)*PIX_W +: PIX_W] = wsel[j][i*PIX_W +: PIX_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_l  <= '0;
         col_m  <= '0;
         key_q  <= '0;
         ctr_q  <= '0;
         emit_q <= 1'b0;
         sof_q  <= 1'b0;
         eol_q  <= 1'b0;
      end else begin
         emit_q <= emit;
         sof_q  <= emit && sof_mark;
         eol_q  <= emit && eol_mark;
         if (step) begin
            col_l <= col_m;
            col_m <= col_n;
            key_q <= key_d;
            ctr_q <= col_m[PIX_W +: PIX_W];
         end
      end
   end

endmodule

// File: rtl/nbhd_pattab.sv
module nbhd_pattab #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned PIX_W   = 2,
   localparam int unsigned KEY_W  = nbhd_sieve_pkg::key_bits(PIX_W),
   localparam int unsigned NPIX   = nbhd_sieve_pkg::WIN_PIX,
   localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [KEY_W-1:0] wr_key,
   input  logic             wr_keep,
   input  logic [KEY_W-1:0] look_key,
   input  logic             grey,
   output logic             hit
);

   logic [NPIX-1:0]    bin_key;
   logic [ENTRIES-1:0] eq_vec;

   for (genvar k = 0; k < NPIX; k++) begin : g_bin
      assign bin_key[k] = look_key[k*PIX_W];
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [KEY_W-1:0] ent_key;
      logic             ent_ok;
      logic             sel;
      assign sel = wr_en && (wr_idx == IW'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ent_ok <= 1'b0;
         else if (sel) ent_ok <= wr_keep;
      end
      always_ff @(posedge clk) begin
         if (sel) ent_key <= wr_key;
      end
      assign eq_vec[e] = ent_ok && (grey ? (ent_key == look_key)
                                         : (ent_key[NPIX-1:0] == bin_key));
   end

   assign hit = |eq_vec;

endmodule

// File: rtl/nbhd_sieve.sv
module nbhd_sieve #(
   parameter int unsigned COLS    = 16,
   parameter int unsigned ROWS    = 8,
   parameter int unsigned PIX_W   = 2,
   parameter int unsigned ENTRIES = 32,
   localparam int unsigned KEY_W  = nbhd_sieve_pkg::key_bits(PIX_W),
   localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int unsigned CW     = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int unsigned RW     = $clog2(ROWS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_grey,
   input  logic             in_vld,
   input  logic             in_sof,
   input  logic [PIX_W-1:0] in_pix,
   input  logic             tw_en,
   input  logic [IW-1:0]    tw_idx,
   input  logic [KEY_W-1:0] tw_key,
   input  logic             tw_keep,
   output logic             out_vld,
   output logic             out_sof,
   output logic             out_eol,
   output logic [PIX_W-1:0] out_pix
);
   import nbhd_sieve_pkg::*;

   if (COLS < 2)   begin : g_bad_cols $error("nbhd_sieve: COLS must be at least 2");   end
   if (ROWS < 2)   begin : g_bad_rows $error("nbhd_sieve: ROWS must be at least 2");   end
   if (PIX_W < 1)  begin : g_bad_pix  $error("nbhd_sieve: PIX_W must be at least 1");  end
   if (ENTRIES < 1) begin : g_bad_ent $error("nbhd_sieve: ENTRIES must be at least 1"); end

   seq_state_e       state;
   logic [RW-1:0]    row_q;
   logic [CW-1:0]    col_q;
   logic             flushing, take_in, step, at_last_col;
   logic [RW-1:0]    cur_row;
   logic [CW-1:0]    cur_col;
   logic [PIX_W-1:0] pix_eff;
   logic             emit, sof_mark, eol_mark;

   always_comb begin
      flushing    = (state == SEQ_FLUSH);
      take_in     = in_vld && !flushing && (in_sof || state == SEQ_RUN);
      step        = take_in || flushing;
      cur_row     = (take_in && in_sof) ? '0 : row_q;
      cur_col     = (take_in && in_sof) ? '0 : col_q;
      pix_eff     = take_in ? in_pix : '0;
      at_last_col = (cur_col == CW'(COLS - 1));
      // a step at column c>0 completes the pixel one row up, one column left;
      // a step at column 0 completes the last pixel two rows up
      emit        = step && (((cur_col != '0) && (cur_row != '0)) ||
                             ((cur_col == '0) && (cur_row >= RW'(2))));
      sof_mark    = (cur_row == RW'(1)) && (cur_col == CW'(1));
      eol_mark    = (cur_col == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         row_q <= '0;
         col_q <= '0;
      end else if (step) begin
         col_q <= at_last_col ? '0 : cur_col + 1'b1;
         row_q <= at_last_col ? cur_row + 1'b1 : cur_row;
         if (take_in && at_last_col && cur_row == RW'(ROWS - 1)) state <= SEQ_FLUSH;
         else if (flushing && cur_row == RW'(ROWS + 1))          state <= SEQ_IDLE;
         else if (take_in)                                       state <= SEQ_RUN;
      end
   end

   logic [PIX_W-1:0] c_top, c_mid, c_bot;

   nbhd_linebuf #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) lines_i (
      .clk     (clk),
      .step    (step),
      .col     (cur_col),
      .row     (cur_row),
      .pix_new (pix_eff),
      .col_top (c_top),
      .col_mid (c_mid),
      .col_bot (c_bot)
   );

   logic [KEY_W-1:0] key_q;
   logic [PIX_W-1:0] ctr_q;
   logic             emit_q, sof_q, eol_q;

   nbhd_keyform #(.PIX_W(PIX_W)) keys_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .new_top    (c_top),
      .new_mid    (c_mid),
      .new_bot    (c_bot),
      .kill_left  (cur_col == CW'(1)),
      .kill_right (cur_col == '0),
      .emit       (emit),
      .sof_mark   (sof_mark),
      .eol_mark   (eol_mark),
      .key_q      (key_q),
      .ctr_q      (ctr_q),
      .emit_q     (emit_q),
      .sof_q      (sof_q),
      .eol_q      (eol_q)
   );

   logic hit;

   nbhd_pattab #(.ENTRIES(ENTRIES), .PIX_W(PIX_W)) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tw_en),
      .wr_idx   (tw_idx),
      .wr_key   (tw_key),
      .wr_keep  (tw_keep),
      .look_key (key_q),
      .grey     (mode_grey),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_sof <= 1'b0;
         out_eol <= 1'b0;
         out_pix <= '0;
      end else begin
         out_vld <= emit_q;
         out_sof <= sof_q;
         out_eol <= eol_q;
         if (emit_q && hit) out_pix <= mode_grey ? ctr_q : (ctr_q & PIX_W'(1));
         else               out_pix <= '0;
      end
   end

endmodule

// File: rtl/nbhd_sieve_chk.sv
module nbhd_sieve_chk #(
   parameter int unsigned COLS  = 16,
   parameter int unsigned PIX_W = 2,
   localparam int unsigned CW   = (COLS > 1) ? $clog2(COLS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_grey,
   input logic             in_vld,
   input logic             flushing,
   input logic             out_vld,
   input logic             out_sof,
   input logic             out_eol,
   input logic [PIX_W-1:0] out_pix
);

   // column of the next output, tracked from the output stream only
   logic [CW-1:0] oc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oc <= '0;
      else if (out_vld) begin
         if (out_sof)                    oc <= CW'(1);
         else if (oc == CW'(COLS - 1))   oc <= '0;
         else                            oc <= oc + 1'b1;
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_vld);

   // R4
   idle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> (out_pix == '0));

   // R4
   binary_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !$past(mode_grey)) |-> ((out_pix >> 1) == '0));

   // R8
   marker_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eol) |-> out_vld);

   // R8
   eol_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_sof) |-> (out_eol == (oc == CW'(COLS - 1))));

   // R8
   sof_not_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> !out_eol);

   // R6
   out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($past(in_vld, 2) || $past(flushing, 2)));

endmodule

bind nbhd_sieve nbhd_sieve_chk #(.COLS(COLS), .PIX_W(PIX_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_grey (mode_grey),
   .in_vld    (in_vld),
   .flushing  (flushing),
   .out_vld   (out_vld),
   .out_sof   (out_sof),
   .out_eol   (out_eol),
   .out_pix   (out_pix)
);

// File: tb/nbhd_sieve_tb_top.sv
module nbhd_sieve_tb_top;

   localparam int COLS = 16;
   localparam int ROWS = 8;
   localparam int PW   = 2;
   localparam int ENT  = 32;
   localparam int KW   = 9 * PW;
   localparam int IW   = $clog2(ENT);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_grey = 1'b0;
   logic          in_vld = 1'b0, in_sof = 1'b0;
   logic [PW-1:0] in_pix = '0;
   logic          tw_en = 1'b0, tw_keep = 1'b0;
   logic [IW-1:0] tw_idx = '0;
   logic [KW-1:0] tw_key = '0;
   logic          out_vld, out_sof, out_eol;
   logic [PW-1:0] out_pix;

   nbhd_sieve #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PW), .ENTRIES(ENT)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_grey(mode_grey),
      .in_vld(in_vld), .in_sof(in_sof), .in_pix(in_pix),
      .tw_en(tw_en), .tw_idx(tw_idx), .tw_key(tw_key), .tw_keep(tw_keep),
      .out_vld(out_vld), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
   );

   always #4 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0, n_out = 0;
   int sof_cyc = 0;
   bit track_first = 0;
   bit done = 0;
   int unsigned seed = 32'h1234_5679;

   logic [PW-1:0] img [ROWS][COLS];
   logic [KW-1:0] bt_key [ENT];
   bit            bt_ok  [ENT];

   typedef struct packed { logic [PW-1:0] p; logic s; logic e; } exp_t;
   exp_t exp_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int unsigned rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic logic [PW-1:0] px(input int r, input int c);
      if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return '0;
      return img[r][c];
   endfunction

   function automatic logic [KW-1:0] grey_key(input int r, input int c);
      logic [KW-1:0] k = '0;
      for (int dr = -1; dr <= 1; dr++)
         for (int dc = -1; dc <= 1; dc++)
            k[((dr+1)*3 + (dc+1))*PW +: PW] = px(r+dr, c+dc);
      return k;
   endfunction

   function automatic logic [PW-1:0] ref_out(input int r, input int c, input bit g);
      logic [KW-1:0] gk = grey_key(r, c);
      logic [8:0]    bk;
      bit            hit = 0;
      for (int k = 0; k < 9; k++) bk[k] = gk[k*PW];
      for (int e = 0; e < ENT; e++)
         if (bt_ok[e] && (g ? (bt_key[e] == gk) : (bt_key[e][8:0] == bk))) hit = 1;
      if (!hit) return '0;
      return g ? img[r][c] : {1'b0, img[r][c][0]};
   endfunction

   // output monitor: compared against the reference stream on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_vld) begin
            n_out++;
            if (track_first) begin
               track_first = 0;
               check(cyc == sof_cyc + COLS + 2, "R6", "first output edge", cyc, sof_cyc + COLS + 2);
            end
            if (exp_q.size() == 0) begin
               check(0, "R7 R10", "output with nothing pending", int'(out_pix), -1);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check({out_pix, out_sof, out_eol} == e, "R2 R3 R4 R5 R6 R8 R11 stream",
                     "pix/sof/eol", int'({out_pix, out_sof, out_eol}), int'(e));
            end
         end else begin
            check(out_pix == '0, "R4", "pixel while idle", int'(out_pix), 0);
         end
      end
   end

   task automatic tw(input int idx, input logic [KW-1:0] key, input bit keep);
      tw_en = 1'b1; tw_idx = IW'(idx); tw_key = key; tw_keep = keep;
      @(negedge clk);
      tw_en = 1'b0;
      bt_key[idx] = key; bt_ok[idx] = keep;
   endtask

   task automatic fill_binary();
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) begin
            int unsigned v = rnd();
            img[r][c] = {v[5], v[1:0] == 2'b00};
         end
      for (int c = 0; c < COLS; c++) img[3][c][0] = 1'b1;
      for (int r = 4; r <= 6; r++)
         for (int c = 9; c <= 11; c++) img[r][c][0] = 1'b1;
   endtask

   task automatic fill_grey();
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) img[r][c] = PW'(rnd() >> 7);
   endtask

   task automatic run_frame(input bit gaps, input bit junk, input bit time_first);
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            exp_q.push_back({ref_out(r, c, mode_grey), r == 0 && c == 0, c == COLS - 1});
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) begin
            if (gaps) begin
               while (rnd() % 4 == 0) begin
                  in_vld = 1'b0; in_pix = PW'(rnd()); @(negedge clk);
               end
            end
            in_vld = 1'b1; in_sof = (r == 0 && c == 0); in_pix = img[r][c];
            if (r == 0 && c == 0 && time_first) begin
               sof_cyc = cyc + 1; track_first = 1;
            end
            @(negedge clk);
         end
      in_sof = 1'b0;
      // R7: junk during the flush, including a stray start marker
      for (int i = 0; i <= COLS; i++) begin
         in_vld = junk; in_sof = junk && (i == 3); in_pix = PW'(rnd());
         @(negedge clk);
      end
      in_vld = 1'b0; in_sof = 1'b0;
      repeat (COLS + 6) @(negedge clk);
      check(exp_q.size() == 0, "R6 R7", "outputs left pending", exp_q.size(), 0);
   endtask

   initial begin
      for (int e = 0; e < ENT; e++) begin bt_ok[e] = 0; bt_key[e] = '0; end
      repeat (3) @(negedge clk);
      check(out_vld == 1'b0 && out_pix == '0, "R1", "outputs in reset",
            int'({out_vld, out_pix}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: pixels with no open frame
      for (int i = 0; i < 6; i++) begin
         in_vld = 1'b1; in_pix = PW'(rnd()); @(negedge clk);
      end
      in_vld = 1'b0;
      repeat (6) @(negedge clk);
      check(n_out == 0, "R10", "outputs from unframed pixels", n_out, 0);

      // R1: empty table blanks everything; R6 first-output timing
      mode_grey = 1'b0;
      fill_binary();
      run_frame(0, 0, 1);

      // R2 R11: binary patterns, one carrying junk above bit 8
      tw(0, 18'h0_0000, 1);
      tw(1, 18'h0_0010, 1);
      tw(2, 18'h0_0038, 1);
      tw(3, {9'h15A, 9'h1FF}, 1);
      fill_binary();
      check(ref_out(5, 10, 0) == 2'b01, "R11", "bench sanity for upper junk", int'(ref_out(5, 10, 0)), 1);
      run_frame(1, 1, 0);

      // R3 R5: grey patterns taken from the image, corners included
      for (int e = 0; e < 4; e++) tw(e, '0, 0);
      mode_grey = 1'b1;
      fill_grey();
      tw(4,  grey_key(0, 0), 1);
      tw(5,  grey_key(0, COLS - 1), 1);
      tw(6,  grey_key(ROWS - 1, 0), 1);
      tw(7,  grey_key(ROWS - 1, COLS - 1), 1);
      tw(8,  grey_key(3, 5), 1);
      tw(9,  grey_key(4, 8), 1);
      tw(10, grey_key(2, 12), 1);
      tw(ENT - 1, grey_key(6, 3), 1);
      run_frame(1, 1, 0);

      // R9: removing an entry takes effect on the next frame
      tw(4, grey_key(0, 0), 0);
      tw(ENT - 1, grey_key(6, 3), 0);
      run_frame(0, 1, 1);

      // R2: binary mode on a grey image, bit 1 must not matter
      mode_grey = 1'b0;
      tw(0, 18'h0_0000, 1);
      tw(1, 18'h0_01FF, 1);
      tw(2, 18'h0_0092, 1);
      run_frame(1, 0, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule